// File: doc/BRIEF.md
# Direct-Mapped Four-Word-Line Read Cache

This block is a read-only cache with one way per set. Requests carry a word address. The low bits pick a word inside a four-word line, the next bits pick one of 4096 lines, and the remaining upper bits form the tag. Each line keeps a tag and a valid flag. A request hits when the indexed line is valid and its stored tag equals the request tag. A hit returns the stored word straight away.

On a miss the cache raises `busy` and sends one line request to a memory-side port. The address of that request is aligned to the start of the four-word block. The memory answers with four beats, each a `memRspValid` strobe with a word, in offset order. After the fourth beat the cache writes the line, its tag and its valid flag, and returns the requested word. New requests are held off through `reqReady` until the cache is idle again. Two free-running counters report how many lookups hit and how many missed.

Top module: `dmcache`

## Requirements
- R1: The word address splits as offset = addr[1:0], line index = addr[13:2] (block number modulo 4096) and tag = addr[31:14] (addr divided by 16384). Word 17001 therefore uses line 154, offset 1, tag 1, and it conflicts with word 617 (line 154, tag 0).
- R2: Reset clears every valid flag and both counters. After reset `reqReady` is 1 and `busy`, `rspValid` and `memReqValid` are 0.
- R3: On a hit, `rspValid` rises for one cycle at the clock edge after the one that accepted the request. It carries `rspHit`=1 and the stored word, and no memory request is made.
- R4: On a miss, exactly one memory request is issued. `memReqAddr` is the request address with its two low bits cleared, and `memReqValid` and `memReqAddr` stay stable until `memReqReady` is seen.
- R5: The four refill beats are taken as offsets 0, 1, 2 and 3, and cycles with `memRspValid`=0 between beats are skipped. At the edge of the fourth beat the line is installed, and the response carries `rspHit`=0 and the word at the requested offset.
- R6: `reqReady` is 0 while `busy` is 1. A request offered during a refill waits until the refill has answered, and then it is accepted and served.
- R7: `hitCount` increases by one for each hit response. `missCount` increases by one for each miss, in the cycle the memory request starts.
- R8: For a strictly sequential word stream from a cold cache, exactly one access in four misses: 256 accesses give 64 misses and 192 hits.
- R9: A refill replaces whatever line was at its index, so a later access to the evicted tag misses again.
- R10: Every accepted request produces exactly one `rspValid` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request offered |
| reqReady | output | 1 | Cache can accept a request |
| reqAddr | input | 32 | Word address of the request |
| rspValid | output | 1 | One-cycle response strobe |
| rspHit | output | 1 | Response came from a hit |
| rspData | output | 32 | Returned word |
| busy | output | 1 | Lookup or refill in progress |
| memReqValid | output | 1 | Line refill request |
| memReqReady | input | 1 | Memory takes the refill request |
| memReqAddr | output | 32 | Block-aligned word address of the line |
| memRspValid | input | 1 | Refill beat strobe |
| memRspData | input | 32 | Refill beat word |
| hitCount | output | 32 | Number of hits since reset |
| missCount | output | 32 | Number of misses since reset |

## Verification
The properties assume the memory side behaves:
- it delivers refill beats only after it has accepted a line request;
- it sends exactly four beats per line;
- it never sends a beat while no refill is pending.

The bench memory model keeps to these rules. It raises `memReqReady` for one cycle, then sends four beats with an idle cycle before the third one, and only then looks for the next request. Requests are offered only through the handshake, and the bench resets the cache only while no refill is pending.

// File: rtl/dmcache_pkg.sv
package dmcache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_MREQ,
    ST_FILL
  } cacheState_t;

  typedef struct packed {
    logic capture;    // latch request address, clear beat count
    logic respHit;    // answer from array, count a hit
    logic countMiss;  // count a miss
    logic beat;       // store one refill word
    logic fill;       // install line and answer the miss
  } ctrlStrobes_t;

endpackage

// File: rtl/dmcache_datapath.sv
module dmcache_datapath
  import dmcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 4096,
  parameter int CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] memRspData,
  output logic              hit,
  output logic              lastBeat,
  output logic              rspValid,
  output logic              rspHit,
  output logic [WORD_W-1:0] rspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);

  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = WORD_W * LINE_WORDS;

  logic [LINE_W-1:0] dataArr [LINES];
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [LINES-1:0]  validArr;

  logic [ADDR_W-1:0] addrQ;
  logic [OFF_W-1:0]  beatCnt;
  logic [WORD_W-1:0] fillBuf [LINE_WORDS];

  logic [OFF_W-1:0]  offQ;
  logic [IDX_W-1:0]  idxQ;
  logic [TAG_W-1:0]  tagQ;
  logic [LINE_W-1:0] lineRd;
  logic [LINE_W-1:0] newLine;
  logic [WORD_W-1:0] hitWord;
  logic [WORD_W-1:0] fillWord;

  assign offQ = addrQ[OFF_W-1:0];
  assign idxQ = addrQ[OFF_W +: IDX_W];
  assign tagQ = addrQ[ADDR_W-1 -: TAG_W];

  assign lineRd   = dataArr[idxQ];
  assign hit      = validArr[idxQ] && (tagArr[idxQ] == tagQ);
  assign hitWord  = lineRd[offQ*WORD_W +: WORD_W];
  assign lastBeat = (beatCnt == OFF_W'(LINE_WORDS-1));

  // the beat arriving now bypasses the buffer into the line being installed
  for (genvar g = 0; g < LINE_WORDS; g++) begin : g_newLine
    assign newLine[g*WORD_W +: WORD_W] =
      (beatCnt == OFF_W'(g)) ? memRspData : fillBuf[g];
  end
  assign fillWord = newLine[offQ*WORD_W +: WORD_W];

  assign memReqAddr = {addrQ[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (strb.capture) addrQ <= reqAddr;
    if (strb.beat)    fillBuf[beatCnt] <= memRspData;
    if (strb.fill) begin
      dataArr[idxQ] <= newLine;
      tagArr[idxQ]  <= tagQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validArr  <= '0;
      beatCnt   <= '0;
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspData   <= '0;
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      if (strb.capture)      beatCnt <= '0;
      else if (strb.beat)    beatCnt <= beatCnt + 1'b1;
      if (strb.fill)         validArr[idxQ] <= 1'b1;
      rspValid <= strb.respHit | strb.fill;
      if (strb.respHit) begin
        rspHit  <= 1'b1;
        rspData <= hitWord;
      end else if (strb.fill) begin
        rspHit  <= 1'b0;
        rspData <= fillWord;
      end
      if (strb.respHit)   hitCount  <= hitCount + 1'b1;
      if (strb.countMiss) missCount <= missCount + 1'b1;
    end
  end

endmodule

// File: rtl/dmcache_ctrl.sv
module dmcache_ctrl
  import dmcache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         hit,
  input  logic         lastBeat,
  input  logic         memReqReady,
  input  logic         memRspValid,
  output logic         reqReady,
  output logic         busy,
  output logic         memReqValid,
  output ctrlStrobes_t strb
);

  cacheState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    strb        = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.capture = 1'b1;
          nextState    = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (hit) begin
          strb.respHit = 1'b1;
          nextState    = ST_IDLE;
        end else begin
          strb.countMiss = 1'b1;
          nextState      = ST_MREQ;
        end
      end
      ST_MREQ: begin
        memReqValid = 1'b1;
        if (memReqReady) nextState = ST_FILL;
      end
      ST_FILL: begin
        if (memRspValid) begin
          strb.beat = 1'b1;
          if (lastBeat) begin
            strb.fill = 1'b1;
            nextState = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/dmcache.sv
module dmcache
  import dmcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 4096,
  parameter int CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              rspHit,
  output logic [WORD_W-1:0] rspData,
  output logic              busy,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [WORD_W-1:0] memRspData,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);

  ctrlStrobes_t strb;
  logic         hit;
  logic         lastBeat;

  dmcache_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .hit         (hit),
    .lastBeat    (lastBeat),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .reqReady    (reqReady),
    .busy        (busy),
    .memReqValid (memReqValid),
    .strb        (strb)
  );

  dmcache_datapath #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .LINE_WORDS (LINE_WORDS),
    .LINES      (LINES),
    .CNT_W      (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqAddr    (reqAddr),
    .memRspData (memRspData),
    .hit        (hit),
    .lastBeat   (lastBeat),
    .rspValid   (rspValid),
    .rspHit     (rspHit),
    .rspData    (rspData),
    .memReqAddr (memReqAddr),
    .hitCount   (hitCount),
    .missCount  (missCount)
  );

endmodule

// File: rtl/dmcache_chk.sv
module dmcache_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic              rspHit,
  input logic [WORD_W-1:0] rspData,
  input logic              busy,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic [WORD_W-1:0] memRspData,
  input logic [CNT_W-1:0]  hitCount,
  input logic [CNT_W-1:0]  missCount
);

  // R4: refill request held with a stable address until taken
  a_r4_req_stable: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  // R10: a response strobe is a single cycle wide
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R6: a response only ends a busy period
  a_r6_rsp_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(busy));

  // R7: hit counter advances with each hit response
  a_r7_hit_count: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspHit |-> hitCount == $past(hitCount) + 1'b1);

  // R7: miss counter advances as a refill request starts
  a_r7_miss_count: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReqValid) |-> missCount == $past(missCount) + 1'b1);

  // R5: a miss answer follows a refill beat
  a_r5_fill_answer: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspHit |-> $past(memRspValid));

endmodule

bind dmcache dmcache_chk #(
  .ADDR_W (ADDR_W),
  .WORD_W (WORD_W),
  .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/dmcache_tb.sv
`timescale 1ns/1ps
module dmcache_tb;

  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              rspValid;
  logic              rspHit;
  logic [WORD_W-1:0] rspData;
  logic              busy;
  logic              memReqValid;
  logic              memReqReady = 1'b0;
  logic [ADDR_W-1:0] memReqAddr;
  logic              memRspValid = 1'b0;
  logic [WORD_W-1:0] memRspData = '0;
  logic [CNT_W-1:0]  hitCount;
  logic [CNT_W-1:0]  missCount;

  always #2.5 clk = ~clk;

  dmcache u_dut (.*);

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int memReqs = 0;
  logic [ADDR_W-1:0] lastMemAddr = '0;
  logic [WORD_W:0] rspQ [$];
  int rspCycQ [$];
  bit mdlValid [int];
  int mdlTag [int];
  int expHits = 0;
  int expMiss = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [WORD_W-1:0] dataOf(logic [ADDR_W-1:0] a);
    return (a * 32'd2654435761) ^ 32'h1234_5678;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory-side responder
  initial begin
    forever begin
      @(negedge clk);
      if (memReqValid && rstN) begin
        memReqs++;
        lastMemAddr = memReqAddr;
        memReqReady = 1'b1;
        @(negedge clk);
        memReqReady = 1'b0;
        for (int b = 0; b < 4; b++) begin
          if (b == 2) @(negedge clk);
          memRspValid = 1'b1;
          memRspData  = dataOf(lastMemAddr + b);
          @(negedge clk);
          memRspValid = 1'b0;
        end
      end
    end
  end

  // response monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rspValid) begin
        rspQ.push_back({rspHit, rspData});
        rspCycQ.push_back(cyc);
      end
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mdlValid.delete();
    mdlTag.delete();
    expHits = 0;
    expMiss = 0;
    rspQ.delete();
    rspCycQ.delete();
  endtask

  task automatic sendReq(logic [ADDR_W-1:0] a, output int accCyc, output int waited);
    waited = 0;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    while (!reqReady) begin
      waited++;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    accCyc   = cyc;
    reqValid = 1'b0;
  endtask

  task automatic expectRsp(logic [ADDR_W-1:0] a, int accCyc, int memBefore, string req);
    int idx = int'((a >> 2) & 32'hFFF);
    int tg  = int'(a >> 14);
    bit expHit = mdlValid.exists(idx) && (mdlTag[idx] == tg);
    int t = 0;
    logic [WORD_W:0] r;
    int rc;
    while (rspQ.size() == 0 && t < 100) begin
      @(negedge clk);
      t++;
    end
    chk(rspQ.size() > 0, req, "response arrived", rspQ.size(), 1);
    if (rspQ.size() == 0) return;
    r  = rspQ.pop_front();
    rc = rspCycQ.pop_front();
    chk(r[WORD_W-1:0] == dataOf(a), req, "data", r[WORD_W-1:0], dataOf(a));
    chk(r[WORD_W] == expHit, req, "hit flag", r[WORD_W], expHit);
    if (expHit) begin
      expHits++;
      chk(rc - accCyc == 1, "R3", "hit latency", rc - accCyc, 1);
      chk(memReqs == memBefore, "R3", "no memory request on hit", memReqs, memBefore);
    end else begin
      expMiss++;
      mdlValid[idx] = 1'b1;
      mdlTag[idx]   = tg;
      chk(memReqs == memBefore + 1, "R4", "one refill per miss", memReqs, memBefore + 1);
      chk(lastMemAddr == {a[ADDR_W-1:2], 2'b00}, "R4", "aligned refill address",
          lastMemAddr, {a[ADDR_W-1:2], 2'b00});
    end
    @(negedge clk);
    chk(rspQ.size() == 0, "R10", "single response", rspQ.size(), 0);
    chk(hitCount == expHits && missCount == expMiss, "R7", "counters",
        {hitCount, missCount}, {32'(expHits), 32'(expMiss)});
  endtask

  task automatic access(logic [ADDR_W-1:0] a, string req);
    int acc, w;
    int mb = memReqs;
    sendReq(a, acc, w);
    expectRsp(a, acc, mb, req);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : stim
    int accA, accB, w, mb;
    doReset();
    @(negedge clk);
    // R2 reset state
    chk(reqReady && !busy && !rspValid && !memReqValid, "R2", "idle outputs",
        {reqReady, busy, rspValid, memReqValid}, 4'b1000);
    chk(hitCount == 0 && missCount == 0, "R2", "counters cleared", {hitCount, missCount}, 0);

    // R8 sequential stream: 1 miss per 4 words, offsets served by R5
    for (int i = 0; i < 256; i++) access(i, "R8");
    chk(hitCount == 192, "R8", "sequential hits", hitCount, 192);
    chk(missCount == 64, "R8", "sequential misses", missCount, 64);

    // R1 / R9 mapping of word 17001 and its conflict with 617
    access(17001, "R1");
    access(17000, "R1");
    access(17003, "R1");
    access(617,   "R9");
    access(17002, "R9");
    access(616,   "R9");

    // R1 last line index and large tags
    access(32'h0000_3FFF, "R1");
    access(32'h0000_7FFD, "R1");
    access(32'hFFFF_FFFE, "R1");
    access(32'h0000_3FFC, "R9");
    access(32'hFFFF_FFFC, "R1");

    // R6 request held off during a refill
    mb = memReqs;
    sendReq(32'h0001_0042, accA, w);
    sendReq(32'h0001_0043, accB, w);
    chk(w > 0, "R6", "second request waited", w, 1);
    chk(rspQ.size() == 1, "R6", "first answered before second accepted", rspQ.size(), 1);
    expectRsp(32'h0001_0042, accA, mb, "R6");
    expectRsp(32'h0001_0043, accB, memReqs, "R6");

    // R2 reset clears valid flags
    doReset();
    @(negedge clk);
    chk(hitCount == 0 && missCount == 0, "R2", "counters after reset", {hitCount, missCount}, 0);
    access(17001, "R2");
    chk(missCount == 1, "R2", "line invalid after reset", missCount, 1);
    access(17001, "R3");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule